// File: doc/BRIEF.md
# Two-Level FFT Address Sequencer

This block schedules a large FFT of N = n1·n2 points as two passes of small sub-transforms around a local FFT engine that holds at most 512 points. It produces the external-memory read and write address streams for every sub-transform and the twiddle index for the phase rotation between the passes. It also drives the handshake that starts the local engine and waits for it to finish. The butterfly arithmetic, the complex rotator and the memories sit outside. Each 32-bit complex sample (16-bit real, 16-bit imaginary) is read once and written once per pass.

In the first pass, n2 column transforms of n1 points each gather strided samples. Each writes its results back in place, and each written sample carries the rotation index. In the second pass, n1 row transforms of n2 points each read contiguous blocks. They write the final spectrum in transposed order, so the result lands in natural frequency order. A 32768-point transform with n1 = 64 and n2 = 512 needs 131072 external accesses.

Top module: `fft2l_seq`

## Requirements
- R1: While reset is asserted and after it is released with no start, busy, done, mem_rd_en, mem_wr_en, tw_en and eng_go are all 0.
- R2: A start seen while idle latches both size fields (log2 n1, log2 n2). A field of 0 is treated as 1 and a field above 9 is treated as 9, so eng_len_log2 and every address follow the clamped sizes.
- R3: In pass 1, sub-transform k (k = 0 … n2−1 in ascending order) raises mem_rd_en for n1 consecutive cycles with mem_rd_addr = k + n2·j, j ascending. The first read is in the cycle after start is sampled.
- R4: After the last read of each sub-transform, eng_go is high for exactly one cycle, with eng_len_log2 = log2 n1 in pass 1 and log2 n2 in pass 2. The sequencer then waits for an eng_done pulse before it writes.
- R5: In pass 1, sub-transform k writes its n1 results to mem_wr_addr = k + n2·j, j ascending. Each write has tw_en = 1 and tw_idx = (j·k) mod N.
- R6: In pass 2, sub-transform j (j = 0 … n1−1 in ascending order) reads n2 contiguous addresses j·n2 + m, m ascending.
- R7: In pass 2, sub-transform j writes result m to mem_wr_addr = j + n1·m, m ascending, with tw_en = 0.
- R8: Reads and writes never happen in the same cycle, and every read address is below N.
- R9: busy rises in the cycle after start is sampled. done is a one-cycle pulse in the cycle after the final write, and busy is low from that cycle on.
- R10: A start pulse while a transform is in progress is ignored: the access stream and the latched sizes stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transform (accepted only when idle) |
| cfg_log2_n1 | input | 4 | log2 of first-pass sub-transform size |
| cfg_log2_n2 | input | 4 | log2 of second-pass sub-transform size |
| eng_done | input | 1 | Local engine finished the current sub-transform |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | External read strobe |
| mem_rd_addr | output | 18 | External read address |
| mem_wr_en | output | 1 | External write strobe |
| mem_wr_addr | output | 18 | External write address |
| tw_en | output | 1 | Twiddle index valid for the sample being written |
| tw_idx | output | 18 | Rotation index (j·k) mod N |
| eng_go | output | 1 | One-cycle start pulse to the local engine |
| eng_len_log2 | output | 4 | log2 of the current sub-transform size |

## Verification
The first read is due one cycle after start is sampled, and every later access follows in consecutive cycles. The engine pulse comes one cycle after the last read of a sub-transform. Writes begin one cycle after eng_done is sampled, and done comes one cycle after the last write. The bench works out the whole access list of a run ahead of time: reads, engine starts with their sizes, and writes with their twiddle indices. A monitor samples on the falling edge and takes the next expected entry only in cycles where a strobe is high. Ordering is therefore checked exactly, while engine latency stays free. Separate checks sample busy one cycle after start and done one cycle after the last write.

// File: rtl/fft2l_pkg.sv
package fft2l_pkg;
  localparam int unsigned SEQ_MAX_LOG = 9;
  localparam int unsigned SEQ_LOG_W   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_GO,
    ST_WAIT,
    ST_UNLD,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/fft2l_ctrl.sv
module fft2l_ctrl
  import fft2l_pkg::*;
#(
  parameter int MAX_LOG = SEQ_MAX_LOG,
  parameter int LOG_W   = SEQ_LOG_W,
  localparam int CNT_W  = MAX_LOG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LOG_W-1:0] log_n1_in,
  input  logic [LOG_W-1:0] log_n2_in,
  input  logic             eng_done,
  output seq_state_e       state,
  output logic             level,
  output logic [CNT_W-1:0] sub,
  output logic [CNT_W-1:0] idx,
  output logic [LOG_W-1:0] l1,
  output logic [LOG_W-1:0] l2
);
  seq_state_e       state_q, state_d;
  logic             level_q, level_d;
  logic [CNT_W-1:0] sub_q, sub_d, idx_q, idx_d;
  logic [LOG_W-1:0] l1_q, l1_d, l2_q, l2_d;
  logic             adv;

  function automatic logic [LOG_W-1:0] clamp_log(input logic [LOG_W-1:0] v);
    if (v == '0) return LOG_W'(1);
    else if (v > LOG_W'(MAX_LOG)) return LOG_W'(MAX_LOG);
    else return v;
  endfunction

  logic [LOG_W-1:0] pt_len, blk_len;
  logic [CNT_W:0]   pt_span, blk_span;
  logic [CNT_W-1:0] pt_last, blk_last;

  always_comb begin
    pt_len   = level_q ? l2_q : l1_q;
    blk_len  = level_q ? l1_q : l2_q;
    pt_span  = (CNT_W+1)'(1) << pt_len;
    blk_span = (CNT_W+1)'(1) << blk_len;
    pt_last  = CNT_W'(pt_span - 1'b1);
    blk_last = CNT_W'(blk_span - 1'b1);
  end

  always_comb begin
    state_d = state_q;
    level_d = level_q;
    sub_d   = sub_q;
    idx_d   = idx_q;
    l1_d    = l1_q;
    l2_d    = l2_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_LOAD;
        level_d = 1'b0;
        sub_d   = '0;
        idx_d   = '0;
        l1_d    = clamp_log(log_n1_in);
        l2_d    = clamp_log(log_n2_in);
      end
      ST_LOAD: begin
        if (idx_q == pt_last) begin
          state_d = ST_GO;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_GO:   state_d = ST_WAIT;
      ST_WAIT: if (eng_done) state_d = ST_UNLD;
      ST_UNLD: begin
        if (idx_q == pt_last) begin
          idx_d = '0;
          if (sub_q == blk_last) begin
            sub_d = '0;
            if (level_q) begin
              state_d = ST_FIN;
            end else begin
              level_d = 1'b1;
              state_d = ST_LOAD;
            end
          end else begin
            sub_d   = sub_q + 1'b1;
            state_d = ST_LOAD;
          end
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign adv = (state_q != ST_IDLE) || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      level_q <= 1'b0;
      sub_q   <= '0;
      idx_q   <= '0;
      l1_q    <= LOG_W'(1);
      l2_q    <= LOG_W'(1);
    end else if (adv) begin
      state_q <= state_d;
      level_q <= level_d;
      sub_q   <= sub_d;
      idx_q   <= idx_d;
      l1_q    <= l1_d;
      l2_q    <= l2_d;
    end
  end

  assign state = state_q;
  assign level = level_q;
  assign sub   = sub_q;
  assign idx   = idx_q;
  assign l1    = l1_q;
  assign l2    = l2_q;
endmodule

// File: rtl/fft2l_addr_gen.sv
module fft2l_addr_gen #(
  parameter int MAX_LOG = 9,
  parameter int LOG_W   = 4,
  localparam int CNT_W  = MAX_LOG,
  localparam int ADDR_W = 2 * MAX_LOG
) (
  input  logic              level,
  input  logic [CNT_W-1:0]  sub,
  input  logic [CNT_W-1:0]  idx,
  input  logic [LOG_W-1:0]  l1,
  input  logic [LOG_W-1:0]  l2,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] tw_idx,
  output logic [ADDR_W-1:0] addr_mask
);
  logic [ADDR_W-1:0] sub_w, idx_w, prod;
  logic [ADDR_W:0]   full;
  logic [LOG_W:0]    tot_log;

  always_comb begin
    sub_w     = ADDR_W'(sub);
    idx_w     = ADDR_W'(idx);
    tot_log   = {1'b0, l1} + {1'b0, l2};
    full      = (ADDR_W+1)'(1) << tot_log;
    addr_mask = ADDR_W'(full - 1'b1);
    prod      = sub_w * idx_w;
    tw_idx    = prod & addr_mask;
    if (!level) begin
      // column pass: strided gather, in-place scatter
      rd_addr = sub_w + (idx_w << l2);
      wr_addr = sub_w + (idx_w << l2);
    end else begin
      // row pass: contiguous gather, transposed scatter
      rd_addr = (sub_w << l2) + idx_w;
      wr_addr = sub_w + (idx_w << l1);
    end
  end
endmodule

// File: rtl/fft2l_seq.sv
module fft2l_seq
  import fft2l_pkg::*;
#(
  parameter int MAX_LOG  = SEQ_MAX_LOG,
  parameter int LOG_W    = SEQ_LOG_W,
  localparam int CNT_W   = MAX_LOG,
  localparam int ADDR_W  = 2 * MAX_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LOG_W-1:0]  cfg_log2_n1,
  input  logic [LOG_W-1:0]  cfg_log2_n2,
  input  logic              eng_done,
  output logic              busy,
  output logic              done,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic              tw_en,
  output logic [ADDR_W-1:0] tw_idx,
  output logic              eng_go,
  output logic [LOG_W-1:0]  eng_len_log2
);
  seq_state_e        state;
  logic              level;
  logic [CNT_W-1:0]  sub, idx;
  logic [LOG_W-1:0]  l1, l2;
  logic [ADDR_W-1:0] rd_addr, wr_addr, tw_raw, addr_mask;

  fft2l_ctrl #(.MAX_LOG(MAX_LOG), .LOG_W(LOG_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .log_n1_in (cfg_log2_n1),
    .log_n2_in (cfg_log2_n2),
    .eng_done  (eng_done),
    .state     (state),
    .level     (level),
    .sub       (sub),
    .idx       (idx),
    .l1        (l1),
    .l2        (l2)
  );

  fft2l_addr_gen #(.MAX_LOG(MAX_LOG), .LOG_W(LOG_W)) u_addr (
    .level     (level),
    .sub       (sub),
    .idx       (idx),
    .l1        (l1),
    .l2        (l2),
    .rd_addr   (rd_addr),
    .wr_addr   (wr_addr),
    .tw_idx    (tw_raw),
    .addr_mask (addr_mask)
  );

  always_comb begin
    mem_rd_en    = (state == ST_LOAD);
    mem_wr_en    = (state == ST_UNLD);
    tw_en        = mem_wr_en && !level;
    eng_go       = (state == ST_GO);
    done         = (state == ST_FIN);
    busy         = (state != ST_IDLE) && (state != ST_FIN);
    mem_rd_addr  = rd_addr;
    mem_wr_addr  = wr_addr;
    tw_idx       = tw_raw;
    eng_len_log2 = level ? l2 : l1;
  end
endmodule

// File: rtl/fft2l_seq_chk.sv
module fft2l_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_en,
  input logic              tw_en,
  input logic              eng_go,
  input logic [ADDR_W-1:0] addr_mask
);
  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  // R8
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ((mem_rd_addr & ~addr_mask) == '0));

  // R5
  tw_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tw_en |-> mem_wr_en);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R4
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> (!eng_go && !mem_rd_en && !mem_wr_en));
endmodule

bind fft2l_seq fft2l_seq_chk #(.ADDR_W(ADDR_W)) u_seq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .mem_wr_en   (mem_wr_en),
  .tw_en       (tw_en),
  .eng_go      (eng_go),
  .addr_mask   (addr_mask)
);

// File: tb/tb_fft2l_seq.sv
module tb_fft2l_seq;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  cfg_log2_n1, cfg_log2_n2;
  logic        eng_done;
  logic        busy, done, mem_rd_en, mem_wr_en, tw_en, eng_go;
  logic [17:0] mem_rd_addr, mem_wr_addr, tw_idx;
  logic [3:0]  eng_len_log2;

  fft2l_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_log2_n1(cfg_log2_n1), .cfg_log2_n2(cfg_log2_n2),
    .eng_done(eng_done), .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .tw_en(tw_en), .tw_idx(tw_idx),
    .eng_go(eng_go), .eng_len_log2(eng_len_log2)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    int    kind;   // 0 read, 1 write, 2 engine start
    int    addr;
    int    twe;
    int    tw;
    int    len;
    string tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    exp_done = 0;
  bit    done_seen = 0;
  bit    finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    if (v == 0) return 1;
    if (v > 9) return 9;
    return v;
  endfunction

  function automatic void push(input int kind, input int addr, input int twe,
                               input int tw, input int len, input string tag);
    item_t it;
    it.kind = kind; it.addr = addr; it.twe = twe;
    it.tw = tw; it.len = len; it.tag = tag;
    q.push_back(it);
  endfunction

  // engine model: eng_done three cycles after eng_go
  initial begin
    int cnt;
    cnt = 0;
    eng_done = 1'b0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) eng_done = 1'b1;
      end
      if (eng_go) cnt = 3;
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (exp_done) begin
          chk(done && !busy, "R9 done after last write", int'(done), 1);
          exp_done = 0;
          done_seen = 1;
        end else if (done) begin
          chk(0, "R9 unexpected done", 1, 0);
        end
        if (mem_rd_en || mem_wr_en || eng_go) begin
          int obs;
          obs = mem_rd_en ? 0 : (mem_wr_en ? 1 : 2);
          if (int'(mem_rd_en) + int'(mem_wr_en) + int'(eng_go) > 1)
            chk(0, "R8 strobes overlap", obs, -1);
          if (q.size() == 0) begin
            chk(0, "R10 access with nothing pending", obs, -1);
          end else begin
            item_t e;
            e = q.pop_front();
            if (obs != e.kind) chk(0, {e.tag, " kind"}, obs, e.kind);
            else if (obs == 0) chk(int'(mem_rd_addr) == e.addr, {e.tag, " rd addr"}, int'(mem_rd_addr), e.addr);
            else if (obs == 1) begin
              chk(int'(mem_wr_addr) == e.addr && int'(tw_en) == e.twe,
                  {e.tag, " wr addr/tw_en"}, int'(mem_wr_addr), e.addr);
              if (e.twe != 0) chk(int'(tw_idx) == e.tw, {e.tag, " tw_idx"}, int'(tw_idx), e.tw);
            end else chk(int'(eng_len_log2) == e.len, {e.tag, " len"}, int'(eng_len_log2), e.len);
            if (q.size() == 0) exp_done = 1;
          end
        end
      end
    end
  end

  task automatic run_case(input int c1, input int c2, input bit poke, input string ctag);
    int a, b, n1, n2, nn;
    a = clampv(c1); b = clampv(c2);
    n1 = 1 << a; n2 = 1 << b; nn = n1 * n2;
    for (int k = 0; k < n2; k++) begin
      for (int j = 0; j < n1; j++) push(0, k + n2*j, 0, 0, 0, {ctag, " R3"});
      push(2, 0, 0, 0, a, {ctag, " R4"});
      for (int j = 0; j < n1; j++) push(1, k + n2*j, 1, (j*k) % nn, 0, {ctag, " R5"});
    end
    for (int j = 0; j < n1; j++) begin
      for (int m = 0; m < n2; m++) push(0, j*n2 + m, 0, 0, 0, {ctag, " R6"});
      push(2, 0, 0, 0, b, {ctag, " R4"});
      for (int m = 0; m < n2; m++) push(1, j + n1*m, 0, 0, 0, {ctag, " R7"});
    end
    done_seen = 0;
    @(negedge clk);
    cfg_log2_n1 = 4'(c1); cfg_log2_n2 = 4'(c2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {ctag, " R9 busy after start"}, int'(busy), 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      cfg_log2_n1 = 4'd3; cfg_log2_n2 = 4'd3; start = 1'b1;   // R10 ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!done_seen) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q.size() == 0 && !busy, {ctag, " R10 idle, nothing left"}, q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_log2_n1 = 4'd1; cfg_log2_n2 = 4'd1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd_en && !mem_wr_en && !tw_en && !eng_go,
        "R1 outputs in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd_en && !mem_wr_en && !eng_go,
        "R1 idle after release", int'(mem_rd_en), 0);
    run_case(1, 1, 0, "N4");
    run_case(2, 3, 0, "N32");
    run_case(3, 2, 1, "N32t R10");
    run_case(4, 5, 0, "N512");
    run_case(0, 10, 0, "R2 clamp");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule